// File: doc/BRIEF.md
# Bridge Read Retry Timer

On the local-bus side of a bus-to-PCI bridge, this block tracks a read that has been handed to the PCI side. While that read is outstanding, it counts local-bus clocks. If the wait grows longer than a programmable limit, the block sends a one-cycle retry response that frees the local bus. The PCI-side read is not cancelled and keeps running. When the master later issues the read again, it receives the buffered data if the PCI side has completed by then. If the data is still not ready, the block starts timing again. A limit of zero turns retry generation off.

The same control word holds a self-clearing hard-reset bit. Setting it resets the read tracker, asserts a bridge reset output, pulses an EEPROM reload request and refuses register traffic for a fixed lock-out window. A separate flag compares the limit against the longest safe value for the selected bus-timeout length.

Top module: `bridge_read_retry`

## Requirements
- R1: After `rst`, the control word reads 0x0FFF0000. `lb_rd_ack`, `lb_rd_retry`, `pci_pending`, `bridge_rst` and `eeprom_reload` are all 0.
- R2: The wait limit is the 12-bit field at bits 27:16 of the control word. It can be read and written. Bit 11 is the hard-reset bit. All other bits, including 31:28 and 15:12, read 0 and ignore writes.
- R3: The request edge counts as edge 1. A read whose PCI side has not completed produces a one-cycle `lb_rd_retry` that is first seen after edge L+2, where L is the limit. At that point the read has waited L+1 cycles, which exceeds L.
- R4: After a retry, `pci_pending` stays 1 until `pci_done` arrives. The PCI-side read is not cancelled.
- R5: A limit of 0 never produces a retry, however long the read takes.
- R6: If `pci_done` is sampled at edge k with k ≤ L+2, `lb_rd_ack` pulses after edge k and no retry is sent. When both fall on the same edge, completion wins.
- R7: A re-issued read (`lb_rd_same`) gets `lb_rd_ack` on its own edge if the PCI side has already completed. If it has not, counting restarts and the retry falls again at edge L+2.
- R8: A write with bit 11 set has the following effects. `eeprom_reload` pulses for exactly one cycle. `bridge_rst` is high for exactly 32 cycles. Bit 11 then clears itself.
- R9: During those 32 cycles, every register read or write is answered with `reg_retry` and no `reg_ack`. Register contents do not change.
- R10: A hard reset drops any outstanding read, so `pci_pending` returns to 0.
- R11: `limit_over` is a registered flag that is 1 when the limit exceeds the maximum for `bus_tmo_sel`. The maximums are 11: 0xFFF, 10: 0x7F0, 01: 0x3F0, 00: 0x1F0.
- R12: A register access outside the lock-out gets `reg_ack` one cycle after its request edge. For a read, `reg_rdata` holds the control word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_rd | input | 1 | Control-word read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| reg_ack | output | 1 | Register access accepted |
| reg_retry | output | 1 | Register access refused (lock-out) |
| lb_rd_req | input | 1 | New read forwarded to PCI side |
| lb_rd_same | input | 1 | Master re-issues the outstanding read |
| pci_done | input | 1 | PCI-side read has completed |
| lb_rd_ack | output | 1 | Data returned to local bus |
| lb_rd_retry | output | 1 | Retry response, local bus released |
| pci_pending | output | 1 | PCI-side read still running |
| bridge_rst | output | 1 | Bridge reset during hard reset |
| eeprom_reload | output | 1 | One-cycle configuration reload request |
| bus_tmo_sel | input | 2 | Selected local-bus timeout length |
| limit_over | output | 1 | Limit above the safe maximum |

## Verification
The hardest state to reach is a read that has already been retried and is parked while the PCI side is still busy. In that state, a re-issue must restart the timer and not return data. Reaching it needs a retry first, and then a second request raised before any completion. The bench does this in sequence and measures the second retry edge against L+2. The other difficult case is the exact tie between completion and the retry edge. The vector table places `pci_done` on edge L+2 and on edge L+3 so that both sides of that boundary are covered.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE,
    TRK_WAIT,
    TRK_PARK,
    TRK_HELD
  } trk_state_e;
endpackage

// File: rtl/brt_ctrl_reg.sv
`timescale 1ns/1ps
module brt_ctrl_reg #(
  parameter int DATA_W      = 32,
  parameter int LIMIT_W     = 12,
  parameter int LIMIT_LSB   = 16,
  parameter int HRST_BIT    = 11,
  parameter int LOCK_CYCLES = 32,
  parameter logic [LIMIT_W-1:0] LIMIT_RST = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_ack,
  output logic               reg_retry,
  output logic [LIMIT_W-1:0] limit_q,
  output logic               hrst_q,
  output logic               reload
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

  logic [LOCK_W-1:0] lock_cnt;
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[LIMIT_LSB +: LIMIT_W] = limit_q;
    word[HRST_BIT] = hrst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q   <= LIMIT_RST;
      hrst_q    <= 1'b0;
      lock_cnt  <= '0;
      reload    <= 1'b0;
      reg_ack   <= 1'b0;
      reg_retry <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= 1'b0;
      reg_retry <= 1'b0;
      reload    <= 1'b0;
      if (hrst_q) begin
        if (lock_cnt == LOCK_LAST) begin
          hrst_q   <= 1'b0;
          lock_cnt <= '0;
        end else begin
          lock_cnt <= lock_cnt + 1'b1;
        end
        if (reg_wr || reg_rd) reg_retry <= 1'b1;
      end else if (reg_wr) begin
        limit_q <= reg_wdata[LIMIT_LSB +: LIMIT_W];
        reg_ack <= 1'b1;
        if (reg_wdata[HRST_BIT]) begin
          hrst_q <= 1'b1;
          reload <= 1'b1;
        end
      end else if (reg_rd) begin
        reg_ack   <= 1'b1;
        reg_rdata <= word;
      end
    end
  end

  // R9
  lock_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hrst_q && reg_wr) |=> (reg_retry && !reg_ack && $stable(limit_q)));

  // R8
  reload_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> !reload);

  // R8
  lock_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hrst_q) |-> ($past(lock_cnt) == LOCK_LAST));

  // R12
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_ack && reg_retry));
endmodule

// File: rtl/brt_wait_fsm.sv
`timescale 1ns/1ps
module brt_wait_fsm
  import brt_pkg::*;
#(
  parameter int LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               lb_rd_req,
  input  logic               lb_rd_same,
  input  logic               pci_done,
  output logic               lb_rd_ack,
  output logic               lb_rd_retry,
  output logic               pci_pending
);
  trk_state_e         st;
  logic [LIMIT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= TRK_IDLE;
      wait_cnt    <= '0;
      lb_rd_ack   <= 1'b0;
      lb_rd_retry <= 1'b0;
    end else begin
      lb_rd_ack   <= 1'b0;
      lb_rd_retry <= 1'b0;
      case (st)
        TRK_IDLE: if (lb_rd_req) begin
          st       <= TRK_WAIT;
          wait_cnt <= '0;
        end
        TRK_WAIT: begin
          if (pci_done) begin
            lb_rd_ack <= 1'b1;
            st        <= TRK_IDLE;
          end else if ((limit != '0) && (wait_cnt >= limit)) begin
            lb_rd_retry <= 1'b1;
            st          <= TRK_PARK;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        TRK_PARK: begin
          if (pci_done && lb_rd_same) begin
            lb_rd_ack <= 1'b1;
            st        <= TRK_IDLE;
          end else if (pci_done) begin
            st <= TRK_HELD;
          end else if (lb_rd_same) begin
            st       <= TRK_WAIT;
            wait_cnt <= '0;
          end
        end
        default: if (lb_rd_same) begin
          lb_rd_ack <= 1'b1;
          st        <= TRK_IDLE;
        end
      endcase
    end
  end

  assign pci_pending = (st == TRK_WAIT) || (st == TRK_PARK);

  // R6
  ack_retry_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lb_rd_ack && lb_rd_retry));

  // R5
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    lb_rd_retry |-> ($past(limit) != '0));

  // R4
  retry_keeps_pending_chk: assert property (@(posedge clk) disable iff (rst)
    lb_rd_retry |-> pci_pending);

  // R7
  held_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TRK_HELD && lb_rd_same) |=> lb_rd_ack);
endmodule

// File: rtl/brt_limit_chk.sv
`timescale 1ns/1ps
module brt_limit_chk #(
  parameter int LIMIT_W   = 12,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 9,
  parameter int GUARD     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [SEL_W-1:0]   tmo_sel,
  output logic               limit_over
);
  localparam logic [SEL_W-1:0] SEL_FULL = '1;

  logic [LIMIT_W:0] span;
  logic [LIMIT_W:0] max_lim;

  always_comb begin
    span = (LIMIT_W+1)'(1) << (BASE_LOG2 + int'(tmo_sel));
    if (tmo_sel == SEL_FULL) max_lim = {1'b0, {LIMIT_W{1'b1}}};
    else                     max_lim = span - (LIMIT_W+1)'(GUARD);
  end

  always_ff @(posedge clk) begin
    if (rst) limit_over <= 1'b0;
    else     limit_over <= ({1'b0, limit} > max_lim);
  end

  // R11
  full_window_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tmo_sel) == SEL_FULL) |-> !limit_over);
endmodule

// File: rtl/bridge_read_retry.sv
`timescale 1ns/1ps
module bridge_read_retry #(
  parameter int DATA_W      = 32,
  parameter int LIMIT_W     = 12,
  parameter int LIMIT_LSB   = 16,
  parameter int HRST_BIT    = 11,
  parameter int LOCK_CYCLES = 32,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_ack,
  output logic              reg_retry,
  input  logic              lb_rd_req,
  input  logic              lb_rd_same,
  input  logic              pci_done,
  output logic              lb_rd_ack,
  output logic              lb_rd_retry,
  output logic              pci_pending,
  output logic              bridge_rst,
  output logic              eeprom_reload,
  input  logic [SEL_W-1:0]  bus_tmo_sel,
  output logic              limit_over
);
  logic [LIMIT_W-1:0] limit;
  logic               hrst;
  logic               trk_rst;

  assign trk_rst    = rst || hrst;
  assign bridge_rst = hrst;

  brt_ctrl_reg #(
    .DATA_W(DATA_W), .LIMIT_W(LIMIT_W), .LIMIT_LSB(LIMIT_LSB),
    .HRST_BIT(HRST_BIT), .LOCK_CYCLES(LOCK_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .reg_retry(reg_retry), .limit_q(limit), .hrst_q(hrst),
    .reload(eeprom_reload)
  );

  brt_wait_fsm #(.LIMIT_W(LIMIT_W)) u_fsm (
    .clk(clk), .rst(trk_rst), .limit(limit), .lb_rd_req(lb_rd_req),
    .lb_rd_same(lb_rd_same), .pci_done(pci_done), .lb_rd_ack(lb_rd_ack),
    .lb_rd_retry(lb_rd_retry), .pci_pending(pci_pending)
  );

  brt_limit_chk #(.LIMIT_W(LIMIT_W), .SEL_W(SEL_W)) u_lchk (
    .clk(clk), .rst(rst), .limit(limit), .tmo_sel(bus_tmo_sel),
    .limit_over(limit_over)
  );

  // R10
  hrst_drops_read_chk: assert property (@(posedge clk) disable iff (rst)
    hrst |=> !pci_pending);
endmodule

// File: tb/bridge_read_retry_tb.sv
`timescale 1ns/1ps
module bridge_read_retry_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ack, reg_retry;
  logic        lb_rd_req = 0, lb_rd_same = 0, pci_done = 0;
  logic        lb_rd_ack, lb_rd_retry, pci_pending;
  logic        bridge_rst, eeprom_reload;
  logic [1:0]  bus_tmo_sel = 2'b11;
  logic        limit_over;

  int checks = 0;
  int errors = 0;
  int rst_hi = 0;

  always #10 clk = ~clk;

  bridge_read_retry u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .reg_retry(reg_retry), .lb_rd_req(lb_rd_req), .lb_rd_same(lb_rd_same),
    .pci_done(pci_done), .lb_rd_ack(lb_rd_ack), .lb_rd_retry(lb_rd_retry),
    .pci_pending(pci_pending), .bridge_rst(bridge_rst),
    .eeprom_reload(eeprom_reload), .bus_tmo_sel(bus_tmo_sel),
    .limit_over(limit_over)
  );

  always @(negedge clk) if (bridge_rst) rst_hi++;

  typedef struct packed {
    logic [11:0] lim;
    logic [15:0] done_at;
    logic        exp_ack;
    logic [15:0] exp_n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{12'd1,   16'd0,   1'b0, 16'd3},
    '{12'd3,   16'd0,   1'b0, 16'd5},
    '{12'd20,  16'd0,   1'b0, 16'd22},
    '{12'd20,  16'd10,  1'b1, 16'd10},
    '{12'd8,   16'd10,  1'b1, 16'd10},
    '{12'd8,   16'd11,  1'b0, 16'd10},
    '{12'd0,   16'd300, 1'b1, 16'd300},
    '{12'h1F0, 16'd0,   1'b0, 16'h1F2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_op(input logic wr, input logic [31:0] d,
                        output logic ack, output logic rty,
                        output logic [31:0] rd, output logic rl);
    @(negedge clk);
    reg_wr = wr; reg_rd = !wr; reg_wdata = d;
    @(posedge clk); #1;
    ack = reg_ack; rty = reg_retry; rd = reg_rdata; rl = eeprom_reload;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
  endtask

  // issue a read (same=0 new, same=1 re-issue); count edges to ack or retry
  task automatic run_read(input logic same, input int done_at,
                          output logic got_ack, output int n);
    logic got = 0;
    n = 0; got_ack = 0;
    @(negedge clk);
    if (same) lb_rd_same = 1; else lb_rd_req = 1;
    if (done_at == 1) pci_done = 1;
    while (!got && n < 6000) begin
      @(posedge clk); n++; #1;
      lb_rd_req = 0; lb_rd_same = 0;
      pci_done = (n == done_at - 1);
      if (lb_rd_retry) begin got = 1; got_ack = 0; end
      if (lb_rd_ack)   begin got = 1; got_ack = 1; end
    end
    pci_done = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); pci_done = 1;
    @(negedge clk); pci_done = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a, r, rl, ga;
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 retry", {31'b0, lb_rd_retry}, 0);
    check("R1 ack", {31'b0, lb_rd_ack}, 0);
    check("R1 pending", {31'b0, pci_pending}, 0);
    check("R1 bridge_rst", {31'b0, bridge_rst}, 0);
    check("R1 reload", {31'b0, eeprom_reload}, 0);
    reg_op(0, 0, a, r, d, rl);
    check("R1 ctrl word", d, 32'h0FFF0000);
    check("R12 read ack", {30'b0, a, r}, 32'h2);

    // R2 reserved bits ignored
    reg_op(1, 32'hF123F7FF, a, r, d, rl);
    check("R12 write ack", {31'b0, a}, 1);
    reg_op(0, 0, a, r, d, rl);
    check("R2 reserved read zero", d, 32'h01230000);

    // R3 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      reg_op(1, {4'b0, VECS[i].lim, 16'b0}, a, r, d, rl);
      run_read(0, int'(VECS[i].done_at), ga, n);
      check($sformatf("R3/R5/R6 vec%0d kind", i), {31'b0, ga}, {31'b0, VECS[i].exp_ack});
      check($sformatf("R3/R5/R6 vec%0d edge", i), n, {16'b0, VECS[i].exp_n});
      if (!ga) begin
        // R4 read still pending after retry
        repeat (3) @(posedge clk);
        #1 check("R4 pending after retry", {31'b0, pci_pending}, 1);
        pulse_done();
        #1 check("R4 pending cleared by done", {31'b0, pci_pending}, 0);
        // R7 buffered data returned on re-issue
        run_read(1, 0, ga, n);
        check("R7 held ack", {31'b0, ga}, 1);
        check("R7 held ack edge", n, 1);
      end
    end

    // R7 re-issue before data ready retries again
    reg_op(1, 32'h00040000, a, r, d, rl);
    run_read(0, 0, ga, n);
    check("R7 first retry edge", n, 6);
    run_read(1, 0, ga, n);
    check("R7 second retry kind", {31'b0, ga}, 0);
    check("R7 second retry edge", n, 6);
    pulse_done();
    run_read(1, 0, ga, n);
    check("R7 final ack", {31'b0, ga}, 1);

    // R11 limit_over
    bus_tmo_sel = 2'b00;
    reg_op(1, 32'h01F10000, a, r, d, rl);
    repeat (2) @(negedge clk);
    check("R11 1F1 sel00", {31'b0, limit_over}, 1);
    reg_op(1, 32'h01F00000, a, r, d, rl);
    repeat (2) @(negedge clk);
    check("R11 1F0 sel00", {31'b0, limit_over}, 0);
    bus_tmo_sel = 2'b10;
    reg_op(1, 32'h07F10000, a, r, d, rl);
    repeat (2) @(negedge clk);
    check("R11 7F1 sel10", {31'b0, limit_over}, 1);
    bus_tmo_sel = 2'b01;
    repeat (2) @(negedge clk);
    check("R11 7F1 sel01", {31'b0, limit_over}, 1);
    bus_tmo_sel = 2'b11;
    repeat (2) @(negedge clk);
    check("R11 7F1 sel11", {31'b0, limit_over}, 0);

    // R10 R8 R9 hard reset
    reg_op(1, 32'h00000000, a, r, d, rl);
    @(negedge clk); lb_rd_req = 1;
    @(negedge clk); lb_rd_req = 0;
    check("R10 pending before hrst", {31'b0, pci_pending}, 1);
    rst_hi = 0;
    reg_op(1, 32'h00050800, a, r, d, rl);
    check("R8 reload pulse", {31'b0, rl}, 1);
    @(negedge clk);
    check("R8 reload one cycle", {31'b0, eeprom_reload}, 0);
    check("R10 pending dropped", {31'b0, pci_pending}, 0);
    reg_op(0, 0, a, r, d, rl);
    check("R9 read refused", {30'b0, a, r}, 32'h1);
    reg_op(1, 32'h0ABC0000, a, r, d, rl);
    check("R9 write refused", {30'b0, a, r}, 32'h1);
    while (bridge_rst) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R8 window length", rst_hi, 32);
    reg_op(0, 0, a, r, d, rl);
    check("R9/R8 contents after lock", d, 32'h00050000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule